// File: doc/BRIEF.md
# Oversampled Serial Word Capture

This block receives a slow two-wire serial stream (a bus clock line and a data line) and rebuilds 32-bit words from it using nothing but the fast system clock. The external bus clock is never used to clock a flip-flop. Both lines are brought into the system domain through synchronizer chains of equal depth. The synchronized bus clock is then watched for low-to-high transitions. Each transition causes one data bit to be taken on the same system cycle.

Bits are shifted in at the low end of a word register, so the earliest bit ends up at the top. After the last bit of a word arrives, the finished word is copied to an output register. A single-cycle valid strobe accompanies the copy. The scheme works only when each bus clock phase lasts at least two system cycles. It has a fixed latency of a few system cycles from the bus clock edge at the pin to the capture.

Top module: `sbc_capture`

## Requirements
- R1: The bus clock and data inputs each pass through a synchronizer of SYNC_STAGES flops (default 2) of equal depth, so each sampled data bit is the data-pin level present when the bus clock pin rose.
- R2: A bit is captured only on a low-to-high transition of the synchronized bus clock. Falling edges, and data changes while the bus clock holds its level, capture nothing.
- R3: The internal edge indication and the word_valid_o strobe each last exactly one system clock cycle.
- R4: The first bit received in a word appears at bit 31 (the MSB) of word_o, and the last bit appears at bit 0.
- R5: A bit counter wraps every 32 captured bits. Exactly one word_valid_o pulse is produced per 32 bits, issued when the 32nd bit is captured.
- R6: word_o changes only in the cycle where word_valid_o is high, and it holds its value between strobes.
- R7: A synchronous reset (rst high) clears word_o to zero, word_valid_o to zero, the synchronizers, the bit counter and any partially received word.
- R8: After reset is released, no bit is captured because of the bus clock level that was present during or at release of reset. This holds even if the bus clock is high throughout.
- R9: With SYNC_STAGES = 2, word_valid_o is high in the system cycle after the third rising system clock edge following the rise of the bus clock pin that carries a word's last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk_i | input | 1 | External serial bus clock, asynchronous to clk |
| bus_dat_i | input | 1 | External serial bus data, valid around bus clock rise |
| word_o | output | WORD_W | Last completed word, first bit at MSB |
| word_valid_o | output | 1 | One-cycle strobe when word_o is updated |

## Verification
The hardest situation to reach is a reset that arrives mid-word while the bus clock line is held high. In that case the synchronizers are cleared, so they see a false low-to-high step once reset is released. The stimulus sends ten bits and asserts reset with the bus clock high. It then releases reset while the bus clock is still high, and only later lets the bus run again. Any spurious or carried-over bit would misalign the next full word, which is compared in full. Data toggled late in each high phase and a cycle-exact latency measurement on a word's final edge cover sampling alignment.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
   localparam int unsigned SBC_WORD_W_DEF = 32;
   localparam int unsigned SBC_SYNC_DEF   = 2;
endpackage

// File: rtl/sbc_sync.sv
`timescale 1ns/1ps
module sbc_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("sbc_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) stage_q[0] <= '0;
      else     stage_q[0] <= async_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stage_q[i] <= '0;
         else     stage_q[i] <= stage_q[i-1];
      end

      p_chain_shift_r1 : assert property (@(posedge clk) disable iff (rst)
         stage_q[i] == $past(stage_q[i-1]));
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbc_edge.sv
`timescale 1ns/1ps
module sbc_edge #(
   parameter int unsigned SETTLE = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);
   localparam int unsigned CW = $clog2(SETTLE + 1);
   localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE);

   logic [CW-1:0] settle_q;
   logic          prev_q;
   logic          armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         settle_q <= '0;
         prev_q   <= lvl_i;
      end else begin
         prev_q <= lvl_i;
         if (settle_q != SETTLE_V) settle_q <= settle_q + CW'(1);
      end
   end

   assign armed  = (settle_q == SETTLE_V);
   assign rise_o = armed & lvl_i & ~prev_q;

   p_rise_pulse_r3 : assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);
   p_rise_from_low_r2 : assert property (@(posedge clk) disable iff (rst)
      rise_o |-> (lvl_i && !$past(lvl_i)));
endmodule

// File: rtl/sbc_deser.sv
`timescale 1ns/1ps
module sbc_deser #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shift_q;
   logic [WORD_W-1:0] shift_nx;
   logic [CNT_W-1:0]  cnt_q;

   assign shift_nx = {shift_q[WORD_W-2:0], bit_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q <= '0;
         cnt_q   <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (take_i) begin
            shift_q <= shift_nx;
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               word_o  <= shift_nx;
               valid_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   p_strobe_at_wrap_r5 : assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (cnt_q == '0));
   p_strobe_pulse_r3 : assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
   p_word_hold_r6 : assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> $stable(word_o));
   p_count_range_r5 : assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);
endmodule

// File: rtl/sbc_capture.sv
`timescale 1ns/1ps
module sbc_capture
   import sbc_pkg::*;
#(
   parameter int unsigned WORD_W      = SBC_WORD_W_DEF,
   parameter int unsigned SYNC_STAGES = SBC_SYNC_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_clk_i,
   input  logic              bus_dat_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_valid_o
);
   localparam int unsigned SETTLE = SYNC_STAGES + 1;

   if (WORD_W < 2) begin : g_bad_width
      $error("sbc_capture: WORD_W must be at least 2");
   end

   logic [1:0] pins_sync;
   logic       rise;

   sbc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i ({bus_dat_i, bus_clk_i}),
      .sync_o  (pins_sync)
   );

   sbc_edge #(.SETTLE(SETTLE)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (pins_sync[0]),
      .rise_o (rise)
   );

   sbc_deser #(.WORD_W(WORD_W)) u_deser (
      .clk     (clk),
      .rst     (rst),
      .take_i  (rise),
      .bit_i   (pins_sync[1]),
      .word_o  (word_o),
      .valid_o (word_valid_o)
   );

   p_valid_needs_edge_r2 : assert property (@(posedge clk) disable iff (rst)
      word_valid_o |-> $past(rise));
endmodule

// File: tb/sbc_capture_test.sv
`timescale 1ns/1ps
module sbc_capture_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bclk = 1'b0;
   logic        bdat = 1'b0;
   logic [31:0] word;
   logic        wvalid;

   int          n_chk = 0;
   int          n_bad = 0;
   int          rx_n = 0;
   logic [31:0] rx_words [0:63];
   logic [31:0] last_word = '0;
   logic        last_valid = 1'b0;

   always #2.5 clk = ~clk;

   sbc_capture uut (
      .clk          (clk),
      .rst          (rst),
      .bus_clk_i    (bclk),
      .bus_dat_i    (bdat),
      .word_o       (word),
      .word_valid_o (wvalid)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: record strobed words, check strobe width and output hold
   always @(negedge clk) begin
      if (rst) begin
         last_word  = word;
         last_valid = 1'b0;
      end else begin
         if (wvalid) begin
            chk(!last_valid, "R3 strobe longer than one cycle", 32'(wvalid), 32'(0));
            if (rx_n < 64) rx_words[rx_n] = word;
            rx_n++;
         end else begin
            chk(word == last_word, "R6 word changed without strobe", word, last_word);
         end
         last_word  = word;
         last_valid = wvalid;
      end
   end

   task automatic drive_bit(input logic b, input int hi, input int lo);
      bdat = b;
      repeat (lo) @(negedge clk);
      bclk = 1'b1;
      repeat (hi) @(negedge clk);
      bclk = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] w, input int hi, input int lo, input string tag);
      int n0 = rx_n;
      for (int i = 31; i >= 0; i--) drive_bit(w[i], hi, lo);
      repeat (8) @(negedge clk);
      chk(rx_n == n0 + 1, "R5 strobe count per word", 32'(rx_n), 32'(n0 + 1));
      chk(rx_words[n0] == w, tag, rx_words[n0], w);
   endtask

   task automatic t_reset_state();
      chk(word == 32'h0, "R7 word after reset", word, 32'h0);
      chk(wvalid == 1'b0, "R7 strobe after reset", 32'(wvalid), 32'(0));
   endtask

   task automatic t_ratio(input int hi, input int lo);
      for (int k = 0; k < 3; k++) xfer($urandom, hi, lo, "R2/R5 random word mismatch");
   endtask

   task automatic t_msb_order();
      xfer(32'h8000_0001, 3, 3, "R4 first bit at MSB");
      chk(word[31] == 1'b1, "R4 bit 31 set", 32'(word[31]), 32'(1));
      xfer(32'h0000_0001, 3, 3, "R4 last bit at LSB");
   endtask

   task automatic t_latency();
      logic [31:0] w = 32'hC3A5_5A3C;
      int n0 = rx_n;
      int first = 0;
      for (int i = 31; i >= 1; i--) drive_bit(w[i], 4, 4);
      bdat = w[0];
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      for (int c = 1; c <= 6; c++) begin
         @(negedge clk);
         if (wvalid && first == 0) first = c;
      end
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      chk(first == 3, "R9 strobe latency in cycles", 32'(first), 32'(3));
      chk(rx_words[n0] == w, "R1/R9 word at fixed latency", rx_words[n0], w);
   endtask

   task automatic t_data_glitch();
      logic [31:0] w = 32'h1234_FEDC;
      int n0 = rx_n;
      for (int i = 31; i >= 0; i--) begin
         bdat = w[i];
         repeat (3) @(negedge clk);
         bclk = 1'b1;
         repeat (3) @(negedge clk);
         bdat = ~w[i];
         repeat (3) @(negedge clk);
         bclk = 1'b0;
      end
      for (int j = 0; j < 6; j++) begin
         bdat = ~bdat;
         repeat (2) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk(rx_n == n0 + 1, "R2 strobes with data toggling", 32'(rx_n), 32'(n0 + 1));
      chk(rx_words[n0] == w, "R1/R2 data sampled at clock rise", rx_words[n0], w);
   endtask

   task automatic t_reset_midword();
      int n0;
      for (int i = 0; i < 10; i++) drive_bit(i[0], 3, 3);
      bclk = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      repeat (4) @(negedge clk);
      chk(word == 32'h0, "R7 word cleared by reset", word, 32'h0);
      chk(wvalid == 1'b0, "R7 strobe low in reset", 32'(wvalid), 32'(0));
      n0 = rx_n;
      rst = 1'b0;
      repeat (10) @(negedge clk);
      chk(rx_n == n0, "R8 no strobe after release with clock high", 32'(rx_n), 32'(n0));
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      xfer(32'hA5F0_0F5A, 2, 2, "R7/R8 first word after mid-word reset");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_ratio(2, 2);
      t_ratio(3, 5);
      t_ratio(7, 4);
      t_ratio(2, 3);
      t_msb_order();
      t_latency();
      t_data_glitch();
      t_reset_midword();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule